// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers the four interrupt pins of each expansion slot onto sixteen legacy interrupt lines. A fixed per-slot pin map, set by a parameter, sends each pin to one of four shared routing channels (A to D). Four programmable route registers then send each channel to a line number. A two-byte trigger-mode register marks each line as edge or level. A small configuration port with byte writes and a combinational read gives access to all six registers.

The requester inputs are levels, one bit per slot pin. The block compares them with the last serviced level of each requester and handles one changed requester per clock. The lowest index goes first. On an edge line, each rise sends a set pulse and each fall sends a clear pulse to the downstream interrupt controller. On a level line, the block keeps a bitmap per line of the requesters that hold it. It raises the line only for the first holder and clears it only when the last holder lets go. A synchronous router reset drops every holder and clears each line that was held.

Top module: `irq_share_router`

## Requirements
- R1: After `rst_n` is low, route registers A to D (addresses 0 to 3) read 0x80, the low trigger byte (address 4, bit n = line n) reads 0x98 and the high trigger byte (address 5, bit n = line 8+n) reads 0x00. No set or clear pulse is emitted and `irq_busy` is zero.
- R2: A write to address 4 stores the data ANDed with 0xF8, and a write to address 5 stores the data ANDed with 0xDE. Route writes store all 8 bits. Reads of addresses 6 and 7 return 0xFF.
- R3: Lines 0, 1, 2, 8 and 13 behave as edge lines whatever the trigger bytes hold. Every rise of a requester routed there gives a set pulse, even when another requester on the same line is already up.
- R4: A requester whose map entry is 0, or whose channel's route register is above 15, causes no pulse and records no holder.
- R5: On a level line, a rise sets bit `line` of `irq_set` only if the line had no holder. In every case it records the requester as a holder, and `irq_busy[line]` is 1.
- R6: On a level line, a fall of a holder removes only that holder. `irq_clr[line]` pulses only when no holder remains. A fall of a requester that is not a holder does nothing.
- R7: On an edge line, each rise pulses `irq_set[line]` and each fall pulses `irq_clr[line]`, and no holder is recorded.
- R8: At most one requester change is serviced per clock, lowest index (slot*4 + pin) first. Its pulse is visible for one clock, after the edge at which it is serviced.
- R9: `soft_rst` high at an edge empties all holder bitmaps and pulses `irq_clr` for every line that had a holder. No change is serviced in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Router reset: drop all holders |
| req | input | NSLOT*4 | Requester levels, bit slot*4+pin |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| irq_set | output | 16 | One-clock assert request per line |
| irq_clr | output | 16 | One-clock deassert request per line |
| irq_busy | output | 16 | Line has at least one holder |

## Verification
The bench uses the defaults: four slots and a pin map that rotates the channels per slot. The last slot wires only pin A, so unconnected pins and two requesters sharing one channel can both be reached. That map lets two slots sit on the same level line, and one directed test routes a channel to a forced-edge line with both trigger bytes written all ones. A random phase toggles requesters, rewrites routes and trigger bytes, and pulses the router reset. This reaches simultaneous changes and routes that move while a requester holds a line.

// File: rtl/irq_share_router.sv
module irq_share_router #(
  parameter int NSLOT = 4,
  parameter logic [NSLOT*12-1:0] PIN_MAP = {3'd0, 3'd0, 3'd0, 3'd4,
                                            3'd2, 3'd1, 3'd4, 3'd3,
                                            3'd1, 3'd4, 3'd3, 3'd2,
                                            3'd4, 3'd3, 3'd2, 3'd1}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic [NSLOT*4-1:0] req,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  output logic [15:0]        irq_set,
  output logic [15:0]        irq_clr,
  output logic [15:0]        irq_busy
);
  localparam int NREQ = NSLOT * 4;
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [15:0] EDGE_ONLY = 16'h2107;

  logic [NREQ-1:0] seen;
  logic [NREQ-1:0] hold [16];
  logic [7:0] route [4];
  logic [7:0] elcr_lo, elcr_hi;

  logic [NREQ-1:0] diff;
  logic [IW-1:0]   idx;
  logic            found;
  logic [2:0]      map;
  logic [7:0]      rv;
  logic [3:0]      line;
  logic            routed, lvl, up, mine;
  logic [15:0]     lvl_mask;
  logic [NREQ-1:0] others;

  assign diff  = req ^ seen;
  assign found = |diff;

  always_comb begin
    idx = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (diff[i]) idx = IW'(i);
  end

  assign map      = PIN_MAP[idx*3 +: 3];
  assign rv       = route[2'(map - 3'd1)];
  assign routed   = found && (map != 3'd0) && (rv[7:4] == 4'd0);
  assign line     = rv[3:0];
  assign lvl_mask = {elcr_hi, elcr_lo} & ~EDGE_ONLY;
  assign lvl      = lvl_mask[line];
  assign up       = req[idx];
  assign mine     = hold[line][idx];
  assign others   = hold[line] & ~(NREQ'(1) << idx);

  genvar g;
  generate
    for (g = 0; g < 16; g++) begin : g_busy
      assign irq_busy[g] = |hold[g];
    end
  endgenerate

  always_comb begin
    case (cfg_addr)
      3'd0, 3'd1, 3'd2, 3'd3: cfg_rdata = route[cfg_addr[1:0]];
      3'd4:    cfg_rdata = elcr_lo;
      3'd5:    cfg_rdata = elcr_hi;
      default: cfg_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= '0;
      elcr_lo <= 8'h98;
      elcr_hi <= 8'h00;
      irq_set <= '0;
      irq_clr <= '0;
      for (int r = 0; r < 4; r++) route[r] <= 8'h80;
      for (int k = 0; k < 16; k++) hold[k] <= '0;
    end else begin
      irq_set <= '0;
      irq_clr <= '0;
      if (cfg_we) begin
        if (cfg_addr[2] == 1'b0) route[cfg_addr[1:0]] <= cfg_wdata;
        else if (cfg_addr == 3'd4) elcr_lo <= cfg_wdata & 8'hF8;
        else if (cfg_addr == 3'd5) elcr_hi <= cfg_wdata & 8'hDE;
      end
      if (soft_rst) begin
        for (int k = 0; k < 16; k++) begin
          if (|hold[k]) irq_clr[k] <= 1'b1;
          hold[k] <= '0;
        end
      end else if (found) begin
        seen[idx] <= up;
        if (routed) begin
          if (lvl) begin
            if (up && !mine) begin
              if (hold[line] == '0) irq_set[line] <= 1'b1;
              hold[line][idx] <= 1'b1;
            end else if (!up && mine) begin
              hold[line][idx] <= 1'b0;
              if (others == '0) irq_clr[line] <= 1'b1;
            end
          end else if (up) begin
            irq_set[line] <= 1'b1;
          end else begin
            irq_clr[line] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module irq_share_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic [15:0] irq_set,
  input logic [15:0] irq_clr,
  input logic [15:0] irq_busy,
  input logic [7:0]  elcr_lo
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_set) + $countones(irq_clr) <= 1 || $past(soft_rst)); // R8
  AST_SRST_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> irq_set == 16'h0); // R9
  AST_SRST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> irq_busy == 16'h0); // R9
  AST_ELCR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    elcr_lo[2:0] == 3'b000); // R2
  AST_FORCED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_busy & 16'h2107) == 16'h0); // R3
endmodule

bind irq_share_router irq_share_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_set(irq_set),
  .irq_clr(irq_clr), .irq_busy(irq_busy), .elcr_lo(elcr_lo));

// File: tb/irq_share_router_test.sv
module irq_share_router_test;
  localparam int NREQ = 16;

  logic clk = 0, rst_n = 0, soft_rst = 0, cfg_we = 0;
  logic [NREQ-1:0] req = '0;
  logic [2:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [15:0] irq_set, irq_clr, irq_busy;

  irq_share_router uut (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req(req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_set(irq_set), .irq_clr(irq_clr), .irq_busy(irq_busy));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [NREQ-1:0] m_seen;
  logic [NREQ-1:0] m_hold [16];
  logic [7:0] m_route [4];
  logic [7:0] m_lo, m_hi;
  logic [15:0] m_set, m_clr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int map_of(int i);
    int s = i / 4, p = i % 4;
    if (s == 3) return (p == 0) ? 4 : 0;
    return ((s + p) % 4) + 1;
  endfunction

  function automatic bit is_level(int n);
    if (n == 0 || n == 1 || n == 2 || n == 8 || n == 13) return 0;
    return (n < 8) ? m_lo[n] : m_hi[n-8];
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    if (a < 4) return m_route[a];
    if (a == 4) return m_lo;
    if (a == 5) return m_hi;
    return 8'hFF;
  endfunction

  function automatic logic [15:0] m_busy();
    logic [15:0] b;
    for (int k = 0; k < 16; k++) b[k] = |m_hold[k];
    return b;
  endfunction

  task automatic model_reset();
    m_seen = '0; m_lo = 8'h98; m_hi = 8'h00; m_set = '0; m_clr = '0;
    for (int r = 0; r < 4; r++) m_route[r] = 8'h80;
    for (int k = 0; k < 16; k++) m_hold[k] = '0;
  endtask

  task automatic model_step();
    int idx, mp, n;
    logic [NREQ-1:0] d;
    m_set = '0; m_clr = '0;
    if (soft_rst) begin
      for (int k = 0; k < 16; k++) begin
        if (m_hold[k] != 0) m_clr[k] = 1;
        m_hold[k] = '0;
      end
    end else begin
      d = req ^ m_seen; idx = -1;
      for (int i = NREQ - 1; i >= 0; i--) if (d[i]) idx = i;
      if (idx >= 0) begin
        m_seen[idx] = req[idx];
        mp = map_of(idx);
        if (mp != 0 && m_route[mp-1] < 16) begin
          n = m_route[mp-1];
          if (is_level(n)) begin
            if (req[idx] && !m_hold[n][idx]) begin
              if (m_hold[n] == 0) m_set[n] = 1;
              m_hold[n][idx] = 1;
            end else if (!req[idx] && m_hold[n][idx]) begin
              m_hold[n][idx] = 0;
              if (m_hold[n] == 0) m_clr[n] = 1;
            end
          end else if (req[idx]) m_set[n] = 1;
          else m_clr[n] = 1;
        end
      end
    end
    if (cfg_we) begin
      if (cfg_addr < 4) m_route[cfg_addr[1:0]] = cfg_wdata;
      else if (cfg_addr == 4) m_lo = cfg_wdata & 8'hF8;
      else if (cfg_addr == 5) m_hi = cfg_wdata & 8'hDE;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R5 set vs model", irq_set, m_set);
    chk("R6 clr vs model", irq_clr, m_clr);
    chk("R5 busy vs model", irq_busy, m_busy());
    chk("R2 read vs model", cfg_rdata, m_read(cfg_addr));
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] v);
    cfg_we = 1; cfg_addr = a; cfg_wdata = v;
    tick();
    cfg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    cfg_addr = a; #1;
    chk(tag, cfg_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 set idle", irq_set, 0);
    chk("R1 clr idle", irq_clr, 0);
    chk("R1 busy idle", irq_busy, 0);
    rd(0, 8'h80, "R1 route A");
    rd(3, 8'h80, "R1 route D");
    rd(4, 8'h98, "R1 trig lo");
    rd(5, 8'h00, "R1 trig hi");
    rd(6, 8'hFF, "R2 unused addr");

    wr(4, 8'hFF); rd(4, 8'hF8, "R2 lo mask");
    wr(5, 8'hFF); rd(5, 8'hDE, "R2 hi mask");
    wr(4, 8'h00); wr(5, 8'h02);

    // level sharing on line 9: requesters 0 and 7 both use channel A
    wr(0, 8'd9);
    req[0] = 1; tick(); chk("R5 first holder set", irq_set, 16'h0200);
    req[7] = 1; tick(); chk("R5 second holder no set", irq_set, 0);
    chk("R5 busy", irq_busy, 16'h0200);
    req[0] = 0; tick(); chk("R6 holder left", irq_clr, 0);
    req[7] = 0; tick(); chk("R6 last release", irq_clr, 16'h0200);
    chk("R6 busy gone", irq_busy, 0);

    // edge line 5: requesters 1 and 11 on channel B
    wr(1, 8'd5);
    req[1] = 1; tick(); chk("R7 rise 1", irq_set, 16'h0020);
    req[11] = 1; tick(); chk("R7 rise 2", irq_set, 16'h0020);
    chk("R7 no holder", irq_busy, 0);
    req[1] = 0; tick(); chk("R7 fall 1", irq_clr, 16'h0020);
    req[11] = 0; tick(); chk("R7 fall 2", irq_clr, 16'h0020);

    // forced edge line 13
    wr(4, 8'hFF); wr(5, 8'hFF); wr(2, 8'd13);
    req[2] = 1; tick(); chk("R3 rise 1", irq_set, 16'h2000);
    req[8] = 1; tick(); chk("R3 rise 2", irq_set, 16'h2000);
    chk("R3 no holder", irq_busy, 0);
    req[2] = 0; tick(); chk("R3 fall 1", irq_clr, 16'h2000);
    req[8] = 0; tick(); chk("R3 fall 2", irq_clr, 16'h2000);
    wr(4, 8'h00); wr(5, 8'h02);

    // disabled route D and unconnected pin (requester 13)
    req[6] = 1; req[13] = 1;
    tick(); chk("R4 disabled route", irq_set, 0);
    tick(); chk("R4 unconnected pin", irq_set, 0);
    chk("R4 no holder", irq_busy, 0);
    wr(3, 8'h10);
    req[6] = 0; tick(); chk("R4 route above 15", irq_clr, 0);
    req[13] = 0; tick();

    // priority: requesters 2 (C->6) and 6 (D->10) change together
    wr(2, 8'd6); wr(3, 8'd10);
    req[2] = 1; req[6] = 1;
    tick(); chk("R8 lower index first", irq_set, 16'h0040);
    tick(); chk("R8 next index", irq_set, 16'h0400);

    // router reset while line 9 is held
    req[0] = 1; tick(); chk("R5 hold before reset", irq_set, 16'h0200);
    soft_rst = 1; tick(); soft_rst = 0;
    chk("R9 reset clears line", irq_clr, 16'h0200);
    chk("R9 holders empty", irq_busy, 0);
    req[0] = 0; tick(); chk("R9 stale release ignored", irq_clr, 0);
    req[2] = 0; req[6] = 0; tick(); tick();

    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < NREQ; b++)
        if ($urandom_range(0, 9) == 0) req[b] = ~req[b];
      soft_rst = ($urandom_range(0, 99) == 0);
      cfg_we = ($urandom_range(0, 19) == 0);
      cfg_addr = 3'($urandom_range(0, 7));
      cfg_wdata = 8'($urandom);
      if (cfg_addr < 4 && $urandom_range(0, 3) != 0) cfg_wdata = cfg_wdata & 8'h0F;
      tick();
    end
    soft_rst = 0; cfg_we = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule